// File: doc/BRIEF.md
# Framebuffer Mode Geometry Validator

This block takes the raw values a driver has written into the display mode registers and turns them into the geometry that a scan-out engine needs: a pixel format code, the bytes per pixel, the visible width and height, the line stride in bytes, the byte offset of the first displayed pixel, and the total byte size of the visible area. It also decides whether the combination can be displayed at all. The checks are the enable bit, a supported colour depth, a minimum resolution, and the whole visible window fitting inside the video memory.

Every result is registered, so the outputs reflect the register values sampled at the previous clock edge. The block keeps a copy of the last geometry it accepted. It raises a single-cycle change pulse whenever a newly accepted geometry differs from that copy, which a downstream engine uses to rebuild its surface and repaint the whole screen. The video memory size is a parameter and must be a power of two between 4 MiB and 256 MiB.

Top module: `fb_mode_geom`

## Requirements
- R1: While reset is asserted and in the first cycle after it, every output is zero, including `geo_valid` and `geo_changed`.
- R2: If bit 0 of `ctl_enable` is clear, `geo_valid` is 0 whatever the other inputs are. The other bits of `ctl_enable` have no effect.
- R3: A depth of 16 gives format code 1 (5-6-5 RGB) and 2 bytes per pixel. `fb_big_endian` has no effect on this depth.
- R4: A depth of 32 gives 4 bytes per pixel, with format code 2 when `fb_big_endian` is 0 and code 3 when it is 1. Any depth other than 16 or 32 is invalid.
- R5: The line stride is the larger of `line_pixels` and `hres`, multiplied by the bytes per pixel.
- R6: Size is stride × height. Offset is `pan_x` × bytes per pixel plus `pan_y` × stride. Both are computed at full width with no truncation.
- R7: The mode is invalid when `hres` or `vres` is below 64. A value of exactly 64 is accepted.
- R8: The mode is invalid when offset + size exceeds `VRAM_BYTES`. A sum equal to `VRAM_BYTES` is accepted.
- R9: The outputs reflect the inputs sampled at the previous rising clock edge: one cycle of latency, and a new result every cycle.
- R10: `geo_changed` is high for one cycle when an accepted geometry differs from the last accepted one. It stays low when the geometry is unchanged, when the mode is invalid, and when the same geometry is accepted again after an invalid gap.
- R11: While `geo_valid` is 0, all geometry outputs read zero and the format code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_enable | input | REG_W | Enable register; bit 0 turns the mode on |
| depth_bits | input | REG_W | Colour depth in bits per pixel |
| hres | input | REG_W | Visible width in pixels |
| vres | input | REG_W | Visible height in lines |
| line_pixels | input | REG_W | Requested virtual line width in pixels |
| pan_x | input | REG_W | Horizontal start position in pixels |
| pan_y | input | REG_W | Vertical start position in lines |
| fb_big_endian | input | 1 | Byte order for 32-bit pixels |
| geo_fmt | output | 2 | Format code: 0 none, 1 5-6-5, 2 32-bit little-endian, 3 32-bit big-endian |
| geo_bytes | output | 3 | Bytes per pixel |
| geo_width | output | REG_W | Accepted width |
| geo_height | output | REG_W | Accepted height |
| geo_stride | output | REG_W+2 | Line stride in bytes |
| geo_offset | output | 2*REG_W+3 | Start offset in bytes |
| geo_size | output | 2*REG_W+2 | Visible area size in bytes |
| geo_valid | output | 1 | The mode is displayable |
| geo_changed | output | 1 | One-cycle pulse on a new accepted geometry |

## Verification
A wrong value in the registered result shows up directly on the geometry ports one cycle after the inputs that produced it. The reference model therefore compares every field on every clock, and an arithmetic or limit fault is seen in the first cycle in which it matters. A fault in the stored last-accepted geometry has no immediate effect. It appears only later, as a missing or extra change pulse, so the stimulus holds modes steady, alternates between valid and invalid modes, and returns to earlier geometries to expose it. The boundary values 63/64 and an exact fit against memory size catch off-by-one faults in the comparators.

// File: rtl/fbgeo_pkg.sv
package fbgeo_pkg;

    typedef enum logic [1:0] {
        PF_NONE    = 2'd0,
        PF_RGB565  = 2'd1,
        PF_XRGB_LE = 2'd2,
        PF_XRGB_BE = 2'd3
    } pix_fmt_e;

    localparam int unsigned DEPTH_LO = 16;
    localparam int unsigned DEPTH_HI = 32;

endpackage

// File: rtl/fbg_fmt_decode.sv
module fbg_fmt_decode
    import fbgeo_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic [REG_W-1:0] depth,
    input  logic             big_end,
    output pix_fmt_e         fmt,
    output logic [2:0]       bytes_pp,
    output logic             depth_ok
);

    localparam logic [REG_W-1:0] D_LO = REG_W'(DEPTH_LO);
    localparam logic [REG_W-1:0] D_HI = REG_W'(DEPTH_HI);

    always_comb begin
        fmt      = PF_NONE;
        bytes_pp = 3'd0;
        depth_ok = 1'b0;
        if (depth == D_LO) begin
            fmt      = PF_RGB565;
            bytes_pp = 3'd2;
            depth_ok = 1'b1;
        end else if (depth == D_HI) begin
            fmt      = big_end ? PF_XRGB_BE : PF_XRGB_LE;
            bytes_pp = 3'd4;
            depth_ok = 1'b1;
        end
    end

endmodule

// File: rtl/fbg_arith.sv
module fbg_arith #(
    parameter int REG_W = 16,
    localparam int STR_W = REG_W + 2,
    localparam int SZ_W  = STR_W + REG_W,
    localparam int OFS_W = SZ_W + 1
) (
    input  logic [REG_W-1:0] width,
    input  logic [REG_W-1:0] height,
    input  logic [REG_W-1:0] virt_w,
    input  logic [REG_W-1:0] start_x,
    input  logic [REG_W-1:0] start_y,
    input  logic [2:0]       bytes_pp,
    output logic [STR_W-1:0] stride,
    output logic [SZ_W-1:0]  size,
    output logic [OFS_W-1:0] offset
);

    logic [REG_W-1:0] eff_w;

    always_comb begin
        eff_w  = (virt_w < width) ? width : virt_w;
        stride = STR_W'(eff_w) * STR_W'(bytes_pp);
        size   = SZ_W'(stride) * SZ_W'(height);
        offset = OFS_W'(start_x) * OFS_W'(bytes_pp)
               + OFS_W'(start_y) * OFS_W'(stride);
    end

endmodule

// File: rtl/fbg_limit_check.sv
module fbg_limit_check #(
    parameter int              REG_W      = 16,
    parameter longint unsigned VRAM_BYTES = 64'd16777216,
    parameter int              MIN_RES    = 64,
    localparam int STR_W = REG_W + 2,
    localparam int SZ_W  = STR_W + REG_W,
    localparam int OFS_W = SZ_W + 1,
    localparam int SUM_W = OFS_W + 1
) (
    input  logic [REG_W-1:0] width,
    input  logic [REG_W-1:0] height,
    input  logic [SZ_W-1:0]  size,
    input  logic [OFS_W-1:0] offset,
    output logic             res_ok,
    output logic             fits_ok
);

    localparam logic [REG_W-1:0] MIN_V    = REG_W'(MIN_RES);
    localparam logic [SUM_W-1:0] VRAM_LIM = SUM_W'(VRAM_BYTES);

    logic [SUM_W-1:0] end_byte;

    always_comb begin
        end_byte = SUM_W'(offset) + SUM_W'(size);
        res_ok   = (width >= MIN_V) && (height >= MIN_V);
        fits_ok  = (end_byte <= VRAM_LIM);
    end

endmodule

// File: rtl/fb_mode_geom.sv
module fb_mode_geom
    import fbgeo_pkg::*;
#(
    parameter int              REG_W      = 16,
    parameter longint unsigned VRAM_BYTES = 64'd16777216,
    parameter int              MIN_RES    = 64,
    parameter int              EN_BIT     = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [REG_W-1:0]     ctl_enable,
    input  logic [REG_W-1:0]     depth_bits,
    input  logic [REG_W-1:0]     hres,
    input  logic [REG_W-1:0]     vres,
    input  logic [REG_W-1:0]     line_pixels,
    input  logic [REG_W-1:0]     pan_x,
    input  logic [REG_W-1:0]     pan_y,
    input  logic                 fb_big_endian,
    output logic [1:0]           geo_fmt,
    output logic [2:0]           geo_bytes,
    output logic [REG_W-1:0]     geo_width,
    output logic [REG_W-1:0]     geo_height,
    output logic [REG_W+1:0]     geo_stride,
    output logic [2*REG_W+2:0]   geo_offset,
    output logic [2*REG_W+1:0]   geo_size,
    output logic                 geo_valid,
    output logic                 geo_changed
);

    localparam int STR_W = REG_W + 2;
    localparam int SZ_W  = STR_W + REG_W;
    localparam int OFS_W = SZ_W + 1;
    localparam int SUM_W = OFS_W + 1;
    localparam logic [SUM_W-1:0] VRAM_LIM = SUM_W'(VRAM_BYTES);
    localparam logic [REG_W-1:0] MIN_V    = REG_W'(MIN_RES);

    typedef struct packed {
        logic [1:0]       fmt;
        logic [2:0]       bytes_pp;
        logic [REG_W-1:0] width;
        logic [REG_W-1:0] height;
        logic [STR_W-1:0] stride;
        logic [OFS_W-1:0] offset;
        logic [SZ_W-1:0]  size;
    } geom_t;

    typedef struct packed {
        geom_t cur;
        geom_t last;
        logic  ok;
        logic  chg;
    } state_t;

    state_t state_d, state_q;

    pix_fmt_e         fmt_w;
    logic [2:0]       bytes_w;
    logic             depth_ok_w;
    logic [STR_W-1:0] stride_w;
    logic [SZ_W-1:0]  size_w;
    logic [OFS_W-1:0] offset_w;
    logic             res_ok_w;
    logic             fits_ok_w;
    logic             unused_ctl;

    assign unused_ctl = ^ctl_enable;

    fbg_fmt_decode #(.REG_W(REG_W)) u_fmt (
        .depth    (depth_bits),
        .big_end  (fb_big_endian),
        .fmt      (fmt_w),
        .bytes_pp (bytes_w),
        .depth_ok (depth_ok_w)
    );

    fbg_arith #(.REG_W(REG_W)) u_arith (
        .width    (hres),
        .height   (vres),
        .virt_w   (line_pixels),
        .start_x  (pan_x),
        .start_y  (pan_y),
        .bytes_pp (bytes_w),
        .stride   (stride_w),
        .size     (size_w),
        .offset   (offset_w)
    );

    fbg_limit_check #(
        .REG_W      (REG_W),
        .VRAM_BYTES (VRAM_BYTES),
        .MIN_RES    (MIN_RES)
    ) u_limit (
        .width   (hres),
        .height  (vres),
        .size    (size_w),
        .offset  (offset_w),
        .res_ok  (res_ok_w),
        .fits_ok (fits_ok_w)
    );

    geom_t cand;
    logic  cand_ok;

    always_comb begin
        cand.fmt      = fmt_w;
        cand.bytes_pp = bytes_w;
        cand.width    = hres;
        cand.height   = vres;
        cand.stride   = stride_w;
        cand.offset   = offset_w;
        cand.size     = size_w;
        cand_ok       = ctl_enable[EN_BIT] && depth_ok_w && res_ok_w && fits_ok_w;

        state_d       = state_q;
        state_d.ok    = cand_ok;
        state_d.cur   = cand_ok ? cand : '0;
        state_d.chg   = cand_ok && (cand != state_q.last);
        if (cand_ok) begin
            state_d.last = cand;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign geo_fmt     = state_q.cur.fmt;
    assign geo_bytes   = state_q.cur.bytes_pp;
    assign geo_width   = state_q.cur.width;
    assign geo_height  = state_q.cur.height;
    assign geo_stride  = state_q.cur.stride;
    assign geo_offset  = state_q.cur.offset;
    assign geo_size    = state_q.cur.size;
    assign geo_valid   = state_q.ok;
    assign geo_changed = state_q.chg;

    // Change pulse only accompanies an accepted mode (R10)
    p_chg_needs_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        geo_changed |-> geo_valid);

    // Two accepted cycles with identical geometry never pulse (R10)
    p_steady_no_chg_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (geo_valid && $past(geo_valid) && $stable(state_q.cur)) |-> !geo_changed);

    // Rejected modes publish a cleared geometry (R11)
    p_zero_when_bad_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !geo_valid |-> (geo_fmt == 2'd0 && geo_bytes == 3'd0 && geo_size == '0
                        && geo_width == '0 && geo_offset == '0));

    // Accepted resolution is never below the floor (R7)
    p_min_res_r7: assert property (@(posedge clk) disable iff (!rst_n)
        geo_valid |-> (geo_width >= MIN_V && geo_height >= MIN_V));

    // Accepted window ends inside video memory (R8)
    p_fit_r8: assert property (@(posedge clk) disable iff (!rst_n)
        geo_valid |-> (SUM_W'(geo_offset) + SUM_W'(geo_size) <= VRAM_LIM));

    // Stride never shorter than one visible line (R5)
    p_stride_covers_r5: assert property (@(posedge clk) disable iff (!rst_n)
        geo_valid |-> (geo_stride >= STR_W'(geo_width) * STR_W'(geo_bytes)));

    // Pixel size agrees with the format code (R3, R4)
    p_fmt_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        geo_valid |-> ((geo_fmt == 2'd1) ? (geo_bytes == 3'd2) : (geo_bytes == 3'd4)));

endmodule

// File: tb/fb_mode_geom_tb.sv
module fb_mode_geom_tb;

    localparam longint unsigned VRAM = 64'd16777216;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] ctl_enable = '0, depth_bits = '0, hres = '0, vres = '0;
    logic [15:0] line_pixels = '0, pan_x = '0, pan_y = '0;
    logic        fb_big_endian = 1'b0;
    logic [1:0]  geo_fmt;
    logic [2:0]  geo_bytes;
    logic [15:0] geo_width, geo_height;
    logic [17:0] geo_stride;
    logic [34:0] geo_offset;
    logic [33:0] geo_size;
    logic        geo_valid, geo_changed;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    fb_mode_geom #(.VRAM_BYTES(VRAM)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .depth_bits(depth_bits),
        .hres(hres), .vres(vres), .line_pixels(line_pixels), .pan_x(pan_x),
        .pan_y(pan_y), .fb_big_endian(fb_big_endian), .geo_fmt(geo_fmt),
        .geo_bytes(geo_bytes), .geo_width(geo_width), .geo_height(geo_height),
        .geo_stride(geo_stride), .geo_offset(geo_offset), .geo_size(geo_size),
        .geo_valid(geo_valid), .geo_changed(geo_changed)
    );

    // last accepted geometry kept by the reference model
    longint unsigned sh_fmt = 0, sh_by = 0, sh_w = 0, sh_h = 0, sh_st = 0, sh_of = 0, sh_sz = 0;
    string pend_tag = "R1";

    task automatic check_now(input string tag);
        longint unsigned by, fm, effw, st, sz, of;
        bit ok, chg;
        by = 0; fm = 0;
        if (depth_bits == 16) begin by = 2; fm = 1; end
        else if (depth_bits == 32) begin by = 4; fm = fb_big_endian ? 3 : 2; end
        effw = (line_pixels < hres) ? hres : line_pixels;
        st = effw * by;
        sz = st * vres;
        of = pan_x * by + pan_y * st;
        ok = ctl_enable[0] && by != 0 && hres >= 64 && vres >= 64 && (of + sz) <= VRAM;
        chg = 0;
        if (ok) begin
            chg = (fm != sh_fmt) || (by != sh_by) || (hres != sh_w) || (vres != sh_h)
               || (st != sh_st) || (of != sh_of) || (sz != sh_sz);
            sh_fmt = fm; sh_by = by; sh_w = hres; sh_h = vres; sh_st = st; sh_of = of; sh_sz = sz;
        end else begin
            fm = 0; by = 0; st = 0; sz = 0; of = 0;
        end
        tests++;
        if (geo_valid !== ok || geo_changed !== chg || geo_fmt !== 2'(fm)
            || geo_bytes !== 3'(by) || geo_width !== (ok ? hres : 16'd0)
            || geo_height !== (ok ? vres : 16'd0) || geo_stride !== 18'(st)
            || geo_size !== 34'(sz) || geo_offset !== 35'(of)) begin
            fails++;
            $display("FAIL %s: got v=%0d c=%0d f=%0d b=%0d w=%0d h=%0d st=%0d of=%0d sz=%0d exp v=%0d c=%0d f=%0d b=%0d w=%0d h=%0d st=%0d of=%0d sz=%0d",
                tag, geo_valid, geo_changed, geo_fmt, geo_bytes, geo_width, geo_height,
                geo_stride, geo_offset, geo_size, ok, chg, fm, by,
                ok ? hres : 16'd0, ok ? vres : 16'd0, st, of, sz);
        end
    endtask

    // compare the result of the previous stimulus (R9), then apply the next one
    task automatic step(input string tag, input logic [15:0] en, input logic [15:0] dep,
                        input logic [15:0] xr, input logic [15:0] yr, input logic [15:0] vw,
                        input logic [15:0] xo, input logic [15:0] yo, input logic be);
        @(negedge clk);
        check_now(pend_tag);
        ctl_enable = en; depth_bits = dep; hres = xr; vres = yr;
        line_pixels = vw; pan_x = xo; pan_y = yo; fb_big_endian = be;
        pend_tag = tag;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1: outputs cleared while in reset, even with a valid mode presented
        ctl_enable = 16'h1; depth_bits = 16'd32; hres = 16'd640; vres = 16'd480;
        repeat (3) @(negedge clk);
        tests++;
        if (geo_valid !== 1'b0 || geo_changed !== 1'b0 || geo_size !== '0 || geo_fmt !== 2'd0) begin
            fails++;
            $display("FAIL R1: got v=%0d c=%0d sz=%0d exp 0 0 0", geo_valid, geo_changed, geo_size);
        end
        ctl_enable = '0; depth_bits = '0; hres = '0; vres = '0;
        rst_n = 1'b1;
        pend_tag = "R1";
        step("R2_disabled",   16'h0000, 16, 640, 480, 0, 0, 0, 0);
        step("R2_other_bits", 16'hFFFE, 32, 640, 480, 0, 0, 0, 0);
        step("R3_R5_clamp",   16'h0001, 16, 640, 480, 100, 0, 0, 0);
        step("R10_hold",      16'h0001, 16, 640, 480, 100, 0, 0, 0);
        step("R3_be_ignored", 16'h0041, 16, 640, 480, 0, 0, 0, 1);
        step("R4_le",         16'h0001, 32, 640, 480, 0, 0, 0, 0);
        step("R4_be",         16'h0001, 32, 640, 480, 0, 0, 0, 1);
        step("R4_R11_depth24",16'h0001, 24, 640, 480, 0, 0, 0, 1);
        step("R10_regain",    16'h0001, 32, 640, 480, 0, 0, 0, 1);
        step("R2_R10_offgap", 16'h0000, 32, 640, 480, 0, 0, 0, 1);
        step("R10_regain2",   16'h0001, 32, 640, 480, 0, 0, 0, 1);
        step("R5_virt_wide",  16'h0001, 32, 640, 480, 2048, 0, 0, 0);
        step("R6_offsets",    16'h0001, 32, 640, 480, 2048, 3, 5, 0);
        step("R6_offsets16",  16'h0001, 16, 800, 600, 1000, 7, 11, 0);
        step("R7_w63",        16'h0001, 16, 63, 480, 0, 0, 0, 0);
        step("R7_h63",        16'h0001, 16, 640, 63, 0, 0, 0, 0);
        step("R7_64x64",      16'h0001, 16, 64, 64, 0, 0, 0, 0);
        step("R8_exact_fit",  16'h0001, 32, 1024, 768, 0, 0, 3328, 0);
        step("R8_overrun",    16'h0001, 32, 1024, 768, 0, 0, 3329, 0);
        step("R8_R6_huge",    16'h0001, 32, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 0);
        step("R8_xpan_over",  16'h0001, 32, 1024, 1024, 4096, 1, 0, 0);
        step("R8_full_fit",   16'h0001, 32, 4096, 1024, 0, 0, 0, 0);
        for (int i = 0; i < 8; i++) begin
            step("R9_R10_burst", 16'h0001, (i % 2) ? 16'd32 : 16'd16,
                 16'(256 + 8 * i), 16'(200 + i), 16'(i * 40), 16'(i), 16'(i * 3), i[1]);
        end
        step("R10_same_again", 16'h0001, 16, 640, 480, 0, 0, 0, 0);
        step("R10_same_hold",  16'h0001, 16, 640, 480, 0, 0, 0, 0);
        step("R11_idle",       16'h0000, 0, 0, 0, 0, 0, 0, 0);
        step("R11_idle",       16'h0000, 0, 0, 0, 0, 0, 0, 0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule